// File: doc/BRIEF.md
# LCD Panel Power Sequencer

This block brings an LCD controller up and takes it down again by stepping a register-write engine through two fixed command scripts. Each script step names a controller address, a payload length of zero, one or two bytes, and a payload. A start pulse runs the power-up script and a stop pulse runs the power-down script. The block hands the writer exactly one step at a time and waits for the writer's done strobe before it moves on. After each of the three opening null commands it also waits at least a programmable time, 1 ms by default.

Three outputs report status: whether the panel is on, whether a script is running, and whether the writer flagged a fault during the last accepted script. If the writer faults during the opening null commands, power-up stops at once. If it faults later, the script runs to the end and the fault is only recorded. The serial link and all pixel traffic belong to other blocks.

Top module: `lcd_pwr_seq`

## Requirements
- R1: After reset, `busy_o`, `cmd_req_o`, `panel_on_o` and `fault_o` are all 0.
- R2: A start pulse while the panel is off begins with three writes of length 0 to address 0x00. After the writer's done for each of them, the next request waits at least DELAY_CYC cycles, where DELAY_CYC = ceil(CLK_HZ * WAIT_US / 1e6).
- R3: The null writes are followed, in order, by these writes (address=payload, with the length in bytes): 0xB0=0x17 (1), 0xBC=0x80 (1), 0x3B=0x00 (1), 0xB0=0x16 (1), 0xB8=0xFFF9 (2), 0x11 (0). `cmd_len_o` gives the payload byte count. A one-byte payload sits in `cmd_data_o[7:0]` with the upper byte 0. A zero-length write carries data 0.
- R4: The power-up script is exactly 44 writes and its last write is address 0x29 with length 0. Its two-byte writes include 0xC3=0x2040, 0xC7=0x5533, 0xEC=0x01F0 and 0xD3=0x0D0E. `panel_on_o` rises only after the writer's done for that last write.
- R5: A stop pulse while the panel is on issues, in order, 0x28 (0), 0xB8=0x8002 (2), 0x10 (0) and 0xB0=0x00 (1). `panel_on_o` then falls.
- R6: A request stays asserted, with its address, length and payload stable, until the writer's done. Only one write is outstanding at any time.
- R7: A writer fault on any of the three null writes ends power-up at once. No further write is issued, `fault_o` goes to 1, `panel_on_o` stays 0 and `busy_o` drops.
- R8: A writer fault on any later power-up write does not stop the script. All 44 writes are issued, `fault_o` holds 1 at the end and `panel_on_o` rises.
- R9: A start pulse while on, a stop pulse while off, and any pulse while a script is running all have no effect: no write, no status change.
- R10: `fault_o` clears when a new script is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_up_i | input | 1 | One-cycle request to run power-up |
| shut_down_i | input | 1 | One-cycle request to run power-down |
| cmd_req_o | output | 1 | Write request to the register writer, held until done |
| cmd_addr_o | output | 8 | Controller register address |
| cmd_len_o | output | 2 | Payload byte count (0, 1 or 2) |
| cmd_data_o | output | 16 | Payload (one-byte payloads in bits 7:0) |
| cmd_done_i | input | 1 | Writer finished the current write (one-cycle strobe) |
| cmd_fault_i | input | 1 | Writer fault, valid with `cmd_done_i` |
| busy_o | output | 1 | A script is running |
| panel_on_o | output | 1 | Panel is in the active state |
| fault_o | output | 1 | Sticky fault from the last accepted script |

## Verification
The bench first checks that the waits after the null commands are long enough: a design that dropped or shortened the timer would issue the next request within a few cycles of done. It injects a fault on the second null write and expects exactly two writes and the panel still off. A design that ignored the abort would produce 44 writes, and one that aborted too late would produce three. A fault injected mid-configuration must leave all 44 writes issued with `fault_o` set, which catches both a wrongful abort and a fault flag that does not stick. Further checks confirm that a redundant start or stop produces no writes, that a start pulse during a running script does not restart it, and that `panel_on_o` is still low while the final 0x29 write is outstanding.

// File: rtl/lcd_pwr_seq_pkg.sv
// Shared types and script layout for the LCD power sequencer.
// Assumes both scripts live in one index space: power-up first, power-down after.
package lcd_pwr_seq_pkg;

    typedef struct packed {
        logic [1:0]  len;    // payload byte count 0..2
        logic [7:0]  addr;   // controller register
        logic [15:0] data;   // payload, one-byte payloads in [7:0]
        logic        pause;  // timed wait after this step completes
    } step_t;

    localparam int STEPS     = 48;
    localparam int IDX_W     = $clog2(STEPS);
    localparam int UP_FIRST  = 0;
    localparam int NULL_LAST = 2;
    localparam int UP_LAST   = 43;
    localparam int DN_FIRST  = 44;
    localparam int DN_LAST   = 47;

    typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_GAP, ST_HOLD} seq_st_t;

    // Builds one script step.
    function automatic step_t mk(input logic [1:0] len, input logic [7:0] addr,
                                 input logic [15:0] data, input logic pause);
        step_t s;
        s.len   = len;
        s.addr  = addr;
        s.data  = data;
        s.pause = pause;
        return s;
    endfunction

endpackage

// File: rtl/lcd_seq_script.sv
// Script store: maps a step index to its command. Pure combinational lookup.
// Assumes the index space laid out in lcd_pwr_seq_pkg.
module lcd_seq_script
    import lcd_pwr_seq_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output step_t            step
);

    // Step lookup; the order of entries is the sequence the panel requires.
    always_comb begin
        step = mk(2'd0, 8'h00, 16'h0000, 1'b0);
        case (idx)
            6'd0, 6'd1, 6'd2: step = mk(2'd0, 8'h00, 16'h0000, 1'b1);
            6'd3:  step = mk(2'd1, 8'hB0, 16'h0017, 1'b0);
            6'd4:  step = mk(2'd1, 8'hBC, 16'h0080, 1'b0);
            6'd5:  step = mk(2'd1, 8'h3B, 16'h0000, 1'b0);
            6'd6:  step = mk(2'd1, 8'hB0, 16'h0016, 1'b0);
            6'd7:  step = mk(2'd2, 8'hB8, 16'hFFF9, 1'b0);
            6'd8:  step = mk(2'd0, 8'h11, 16'h0000, 1'b0);
            6'd9:  step = mk(2'd1, 8'hBA, 16'h0001, 1'b0);
            6'd10: step = mk(2'd1, 8'hBB, 16'h0000, 1'b0);
            6'd11: step = mk(2'd1, 8'h3A, 16'h0060, 1'b0);
            6'd12: step = mk(2'd1, 8'hBF, 16'h0010, 1'b0);
            6'd13: step = mk(2'd1, 8'hB1, 16'h0056, 1'b0);
            6'd14: step = mk(2'd1, 8'hB2, 16'h0033, 1'b0);
            6'd15, 6'd16: step = mk(2'd1, 8'hB3, 16'h0011, 1'b0);
            6'd17: step = mk(2'd1, 8'hB4, 16'h0002, 1'b0);
            6'd18: step = mk(2'd1, 8'hB5, 16'h002B, 1'b0);
            6'd19: step = mk(2'd1, 8'hB6, 16'h0040, 1'b0);
            6'd20: step = mk(2'd1, 8'hB7, 16'h0003, 1'b0);
            6'd21: step = mk(2'd1, 8'hB9, 16'h0004, 1'b0);
            6'd22: step = mk(2'd1, 8'hBD, 16'h0004, 1'b0);
            6'd23: step = mk(2'd1, 8'hBE, 16'h0000, 1'b0);
            6'd24: step = mk(2'd1, 8'hC0, 16'h0011, 1'b0);
            6'd25: step = mk(2'd1, 8'hC1, 16'h0011, 1'b0);
            6'd26: step = mk(2'd1, 8'hC2, 16'h0011, 1'b0);
            6'd27: step = mk(2'd2, 8'hC3, 16'h2040, 1'b0);
            6'd28: step = mk(2'd2, 8'hC4, 16'h60C0, 1'b0);
            6'd29: step = mk(2'd2, 8'hC5, 16'h1020, 1'b0);
            6'd30: step = mk(2'd2, 8'hC6, 16'h60C0, 1'b0);
            6'd31: step = mk(2'd2, 8'hC7, 16'h5533, 1'b0);
            6'd32: step = mk(2'd1, 8'hC8, 16'h0000, 1'b0);
            6'd33: step = mk(2'd1, 8'hC9, 16'h0000, 1'b0);
            6'd34: step = mk(2'd1, 8'hCA, 16'h0000, 1'b0);
            6'd35: step = mk(2'd2, 8'hEC, 16'h01F0, 1'b0);
            6'd36: step = mk(2'd1, 8'hCF, 16'h0002, 1'b0);
            6'd37: step = mk(2'd2, 8'hD0, 16'h0804, 1'b0);
            6'd38: step = mk(2'd1, 8'hD1, 16'h0001, 1'b0);
            6'd39: step = mk(2'd2, 8'hD2, 16'h0000, 1'b0);
            6'd40: step = mk(2'd2, 8'hD3, 16'h0D0E, 1'b0);
            6'd41: step = mk(2'd2, 8'hD4, 16'h11A4, 1'b0);
            6'd42: step = mk(2'd1, 8'hD5, 16'h000E, 1'b0);
            6'd43: step = mk(2'd0, 8'h29, 16'h0000, 1'b0);
            6'd44: step = mk(2'd0, 8'h28, 16'h0000, 1'b0);
            6'd45: step = mk(2'd2, 8'hB8, 16'h8002, 1'b0);
            6'd46: step = mk(2'd0, 8'h10, 16'h0000, 1'b0);
            6'd47: step = mk(2'd1, 8'hB0, 16'h0000, 1'b0);
            default: ;
        endcase
    end

endmodule

// File: rtl/lcd_seq_timer.sv
// Wait timer: a start strobe loads CYCLES and the timer counts down to zero.
// Assumes start is only given while the timer is idle.
module lcd_seq_timer #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    // Load on start, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (start)
            cnt <= CW'(CYCLES);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    // R2: a new wait never starts on top of a running one
    assert_no_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (cnt == '0));

endmodule

// File: rtl/lcd_seq_ctrl.sv
// Sequencer FSM: accepts start/stop, walks the script one step at a time,
// aborts on a null-phase fault, keeps a sticky fault and the on state.
// Assumes cmd_done_i is a one-cycle strobe that arrives only while cmd_req_o is high.
module lcd_seq_ctrl
    import lcd_pwr_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_up_i,
    input  logic             shut_down_i,
    input  logic             step_pause,
    input  logic             cmd_done_i,
    input  logic             cmd_fault_i,
    input  logic             tmr_busy,
    output logic [IDX_W-1:0] idx,
    output logic             cmd_req_o,
    output logic             tmr_start,
    output logic             busy_o,
    output logic             panel_on_o,
    output logic             fault_o
);

    seq_st_t state;
    logic    going_up;
    logic    at_last;
    logic    abort_now;

    // Step decode: last step of the running script, and null-phase abort.
    always_comb begin
        at_last   = going_up ? (idx == IDX_W'(UP_LAST)) : (idx == IDX_W'(DN_LAST));
        abort_now = cmd_fault_i && going_up && (idx <= IDX_W'(NULL_LAST));
        tmr_start = (state == ST_REQ) && cmd_done_i && step_pause && !abort_now && !at_last;
    end

    // Main sequencing state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            idx        <= '0;
            going_up   <= 1'b0;
            panel_on_o <= 1'b0;
            fault_o    <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_up_i && !panel_on_o) begin
                        idx      <= IDX_W'(UP_FIRST);
                        going_up <= 1'b1;
                        fault_o  <= 1'b0;
                        state    <= ST_REQ;
                    end else if (shut_down_i && panel_on_o) begin
                        idx      <= IDX_W'(DN_FIRST);
                        going_up <= 1'b0;
                        fault_o  <= 1'b0;
                        state    <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (cmd_done_i) begin
                        if (cmd_fault_i)
                            fault_o <= 1'b1;
                        if (abort_now) begin
                            state <= ST_IDLE;
                        end else if (at_last) begin
                            panel_on_o <= going_up;
                            state      <= ST_IDLE;
                        end else begin
                            idx   <= idx + 1'b1;
                            state <= step_pause ? ST_HOLD : ST_GAP;
                        end
                    end
                end
                ST_GAP:  state <= ST_REQ;
                ST_HOLD: if (!tmr_busy) state <= ST_REQ;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign cmd_req_o = (state == ST_REQ);
    assign busy_o    = (state != ST_IDLE);

    // R6: an outstanding step stays posted until the writer completes it
    assert_hold_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req_o && !cmd_done_i) |=> (cmd_req_o && $stable(idx)));

    // R6: after a done strobe the request drops before the next step
    assert_one_at_a_time_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req_o && cmd_done_i) |=> !cmd_req_o);

    // R10: an accepted script starts with a clear fault flag
    assert_fault_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> !fault_o);

endmodule

// File: rtl/lcd_pwr_seq.sv
// Top of the LCD power sequencer: script store, wait timer and control FSM.
// Assumes a register writer that accepts one held request and answers with
// a done strobe plus fault flag. Waits are sized from CLK_HZ and WAIT_US.
module lcd_pwr_seq
    import lcd_pwr_seq_pkg::*;
#(
    parameter int CLK_HZ  = 100_000_000,
    parameter int WAIT_US = 1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_up_i,
    input  logic        shut_down_i,
    output logic        cmd_req_o,
    output logic [7:0]  cmd_addr_o,
    output logic [1:0]  cmd_len_o,
    output logic [15:0] cmd_data_o,
    input  logic        cmd_done_i,
    input  logic        cmd_fault_i,
    output logic        busy_o,
    output logic        panel_on_o,
    output logic        fault_o
);

    localparam longint PROD      = longint'(CLK_HZ) * longint'(WAIT_US);
    localparam longint RAW_CYC   = (PROD + 64'd999_999) / 64'd1_000_000;
    localparam int     DELAY_CYC = (RAW_CYC < 1) ? 1 : int'(RAW_CYC);

    logic [IDX_W-1:0] idx;
    step_t            step;
    logic             tmr_start;
    logic             tmr_busy;

    lcd_seq_script u_script (
        .idx  (idx),
        .step (step)
    );

    lcd_seq_timer #(.CYCLES(DELAY_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .busy  (tmr_busy)
    );

    lcd_seq_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_up_i  (start_up_i),
        .shut_down_i (shut_down_i),
        .step_pause  (step.pause),
        .cmd_done_i  (cmd_done_i),
        .cmd_fault_i (cmd_fault_i),
        .tmr_busy    (tmr_busy),
        .idx         (idx),
        .cmd_req_o   (cmd_req_o),
        .tmr_start   (tmr_start),
        .busy_o      (busy_o),
        .panel_on_o  (panel_on_o),
        .fault_o     (fault_o)
    );

    assign cmd_addr_o = step.addr;
    assign cmd_len_o  = step.len;
    assign cmd_data_o = step.data;

    // R2: no write is posted while a timed wait is running
    assert_wait_blocks_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_busy |-> !cmd_req_o);

    // R4: the panel turns on only on completion of the display-on command
    assert_on_after_final_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(panel_on_o) |-> $past(cmd_done_i && cmd_req_o && cmd_addr_o == 8'h29));

    // R5: the panel turns off only on completion of the last power-down write
    assert_off_after_final_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(panel_on_o) |-> $past(cmd_done_i && cmd_req_o && cmd_addr_o == 8'hB0));

    // R9: a start while on (no stop) is ignored
    assert_ignore_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && panel_on_o && start_up_i && !shut_down_i) |=> !busy_o);

    // R9: a stop while off (no start) is ignored
    assert_ignore_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !panel_on_o && shut_down_i && !start_up_i) |=> !busy_o);

endmodule

// File: tb/sim_lcd_pwr_seq.sv
`timescale 1ns/1ps
module sim_lcd_pwr_seq;

    localparam int CLK_HZ  = 50_000;
    localparam int WAIT_US = 1000;
    localparam int DLY     = 50;   // ceil(50_000 * 1000 / 1e6)
    localparam int LAT     = 3;    // writer latency in cycles

    typedef struct packed {
        logic [1:0]  len;
        logic [7:0]  addr;
        logic [15:0] data;
    } item_t;

    typedef struct {
        item_t it;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_up_i = 1'b0;
    logic        shut_down_i = 1'b0;
    logic        cmd_req_o;
    logic [7:0]  cmd_addr_o;
    logic [1:0]  cmd_len_o;
    logic [15:0] cmd_data_o;
    logic        cmd_done_i = 1'b0;
    logic        cmd_fault_i = 1'b0;
    logic        busy_o;
    logic        panel_on_o;
    logic        fault_o;

    always #2.5 clk = ~clk;

    lcd_pwr_seq #(.CLK_HZ(CLK_HZ), .WAIT_US(WAIT_US)) u0 (
        .clk(clk), .rst_n(rst_n), .start_up_i(start_up_i), .shut_down_i(shut_down_i),
        .cmd_req_o(cmd_req_o), .cmd_addr_o(cmd_addr_o), .cmd_len_o(cmd_len_o),
        .cmd_data_o(cmd_data_o), .cmd_done_i(cmd_done_i), .cmd_fault_i(cmd_fault_i),
        .busy_o(busy_o), .panel_on_o(panel_on_o), .fault_o(fault_o)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    int    done_cyc = 0;
    int    inject_at = -1;
    exp_t  exp_q[$];
    item_t log_a[$];
    int    gap_a[$];
    bit    on_a[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic push_exp(input logic [1:0] len, input logic [7:0] addr,
                            input logic [15:0] data, input string tag);
        exp_t e;
        e.it  = '{len: len, addr: addr, data: data};
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic clear_log();
        log_a.delete();
        gap_a.delete();
        on_a.delete();
    endtask

    task automatic pulse(input bit up);
        @(negedge clk);
        if (up) start_up_i = 1'b1; else shut_down_i = 1'b1;
        @(negedge clk);
        start_up_i  = 1'b0;
        shut_down_i = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (!busy_o) break;
        end
    endtask

    // Writer model and scoreboard monitor: captures each request, compares it
    // with the next expected item, then answers with done (and fault if chosen).
    initial begin
        forever begin
            @(negedge clk);
            if (cmd_req_o) begin
                item_t it;
                it = '{len: cmd_len_o, addr: cmd_addr_o, data: cmd_data_o};
                gap_a.push_back(cyc - done_cyc);
                log_a.push_back(it);
                on_a.push_back(panel_on_o);
                if (exp_q.size() > 0) begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(it == e.it, e.tag, "write {len,addr,data}", longint'(it), longint'(e.it));
                end
                repeat (LAT) @(negedge clk);
                cmd_fault_i = (int'(log_a.size()) - 1 == inject_at);
                cmd_done_i  = 1'b1;
                done_cyc    = cyc;
                @(negedge clk);
                cmd_done_i  = 1'b0;
                cmd_fault_i = 1'b0;
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(busy_o == 0, "R1", "busy", busy_o, 0);
        check(cmd_req_o == 0, "R1", "req", cmd_req_o, 0);
        check(panel_on_o == 0, "R1", "on", panel_on_o, 0);
        check(fault_o == 0, "R1", "fault", fault_o, 0);

        // R9: stop while off does nothing
        clear_log();
        pulse(1'b0);
        repeat (10) @(negedge clk);
        check(log_a.size() == 0, "R9", "writes after stop while off", log_a.size(), 0);
        check(busy_o == 0, "R9", "busy after stop while off", busy_o, 0);
        check(panel_on_o == 0, "R9", "on after stop while off", panel_on_o, 0);

        // R2/R3: ordered opening of power-up
        clear_log();
        for (int i = 0; i < 3; i++) push_exp(2'd0, 8'h00, 16'h0000, "R2");
        push_exp(2'd1, 8'hB0, 16'h0017, "R3");
        push_exp(2'd1, 8'hBC, 16'h0080, "R3");
        push_exp(2'd1, 8'h3B, 16'h0000, "R3");
        push_exp(2'd1, 8'hB0, 16'h0016, "R3");
        push_exp(2'd2, 8'hB8, 16'hFFF9, "R3");
        push_exp(2'd0, 8'h11, 16'h0000, "R3");
        pulse(1'b1);
        repeat (20) @(negedge clk);
        pulse(1'b1);  // R9: ignored while running
        wait_idle();
        check(exp_q.size() == 0, "R3", "expected items left", exp_q.size(), 0);
        for (int i = 1; i <= 3; i++)
            check(gap_a[i] >= DLY, "R2", "cycles from done to next request", gap_a[i], DLY);
        check(log_a.size() == 44, "R4", "power-up write count", log_a.size(), 44);
        check(log_a.size() == 44 && log_a[43] == item_t'{len: 2'd0, addr: 8'h29, data: 16'h0},
              "R4", "final write", log_a.size() > 0 ? longint'(log_a[log_a.size()-1]) : 0,
              longint'(item_t'{len: 2'd0, addr: 8'h29, data: 16'h0}));
        check(on_a.size() == 44 && on_a[43] == 1'b0, "R4", "on during final write",
              on_a.size() > 0 ? on_a[on_a.size()-1] : 1, 0);
        begin
            item_t samples[4];
            samples[0] = '{len: 2'd2, addr: 8'hC3, data: 16'h2040};
            samples[1] = '{len: 2'd2, addr: 8'hC7, data: 16'h5533};
            samples[2] = '{len: 2'd2, addr: 8'hEC, data: 16'h01F0};
            samples[3] = '{len: 2'd2, addr: 8'hD3, data: 16'h0D0E};
            foreach (samples[k]) begin
                bit found = 0;
                foreach (log_a[j]) if (log_a[j] == samples[k]) found = 1;
                check(found, "R4", "two-byte write present", found, 1);
            end
        end
        check(panel_on_o == 1, "R4", "on after power-up", panel_on_o, 1);
        check(fault_o == 0, "R4", "fault after clean power-up", fault_o, 0);

        // R9: start while on does nothing
        clear_log();
        pulse(1'b1);
        repeat (10) @(negedge clk);
        check(log_a.size() == 0, "R9", "writes after start while on", log_a.size(), 0);
        check(busy_o == 0 && panel_on_o == 1, "R9", "status after start while on",
              {busy_o, panel_on_o}, 2'b01);

        // R5: power-down script
        clear_log();
        push_exp(2'd0, 8'h28, 16'h0000, "R5");
        push_exp(2'd2, 8'hB8, 16'h8002, "R5");
        push_exp(2'd0, 8'h10, 16'h0000, "R5");
        push_exp(2'd1, 8'hB0, 16'h0000, "R5");
        pulse(1'b0);
        wait_idle();
        check(log_a.size() == 4, "R5", "power-down write count", log_a.size(), 4);
        check(panel_on_o == 0, "R5", "on after power-down", panel_on_o, 0);
        check(fault_o == 0, "R5", "fault after power-down", fault_o, 0);

        // R7: fault on the second null write aborts
        clear_log();
        inject_at = 1;
        pulse(1'b1);
        wait_idle();
        repeat (DLY + 10) @(negedge clk);
        inject_at = -1;
        check(log_a.size() == 2, "R7", "writes before abort", log_a.size(), 2);
        check(fault_o == 1, "R7", "fault after abort", fault_o, 1);
        check(panel_on_o == 0, "R7", "on after abort", panel_on_o, 0);
        check(busy_o == 0, "R7", "busy after abort", busy_o, 0);

        // R8/R10: configuration fault is recorded, script completes
        clear_log();
        inject_at = 20;
        pulse(1'b1);
        repeat (3) @(negedge clk);
        check(fault_o == 0, "R10", "fault cleared on accepted start", fault_o, 0);
        wait_idle();
        inject_at = -1;
        check(log_a.size() == 44, "R8", "writes despite config fault", log_a.size(), 44);
        check(fault_o == 1, "R8", "sticky fault", fault_o, 1);
        check(panel_on_o == 1, "R8", "on after faulted config", panel_on_o, 1);

        // R10: a clean power-down clears the old fault
        clear_log();
        pulse(1'b0);
        wait_idle();
        check(fault_o == 0, "R10", "fault after clean power-down", fault_o, 0);
        check(panel_on_o == 0, "R10", "on after power-down", panel_on_o, 0);

        summary();
        $finish;
    end

endmodule